// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block runs the digital side of a dual-slope integrating converter. The analog integrator, its input switches and a zero-cross comparator sit outside. The sequencer drives a one-hot switch select that routes one of three sources to the integrator: the unknown input, the negative reference, or a zero path that discharges the integrator. It counts clocks in each phase and watches the comparator.

A conversion starts with a short auto-zero phase. Next comes the run-up phase. In this phase the input is integrated for exactly 2^CNT_W clocks, and the phase ends when the shared phase counter wraps. Then the run-down phase begins. The counter is cleared and the negative reference is integrated until the comparator reports that the integrator is back at zero. The count held at that moment is the result, which is proportional to the ratio of input to reference.

The result leaves on a plain one-clock valid pulse. There is no back-pressure, so the consumer must capture `result` on the cycle that `res_valid` is high. The value stays stable afterwards until the next conversion loads a new one. If the comparator never trips within 2^CNT_W run-down clocks, the result saturates to full scale and an over-range flag is raised. `start` and `zero_cross` are plain level inputs.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `sw_sel` is 3'b100, and `busy`, `res_valid`, `over_range` and `result` are all zero.
- R2: `sw_sel` always has exactly one bit set. Bit 0 routes the input, bit 1 routes the negative reference, and bit 2 routes the zero path. Bit 2 is the one set when idle, during auto-zero and in the done cycle.
- R3: When `start` is sampled high while idle, the block selects the zero path for AZ_CYCLES clocks and then selects the input for exactly 2^CNT_W clocks.
- R4: Run-down begins with the counter at zero, and the negative reference is selected from the clock after run-up ends. If `zero_cross` is first sampled high on run-down clock k (k counted from 0), `result` becomes k. This includes k = 0 when the comparator is already high on the first run-down clock.
- R5: `res_valid` is high for exactly one clock, on the clock after the comparator trip is sampled. `result` and `over_range` then hold until the next load.
- R6: If `zero_cross` stays low for all 2^CNT_W run-down clocks, `result` becomes all ones and `over_range` is set. The next conversion that finishes normally clears `over_range`.
- R7: `start` has no effect while a conversion is in progress. The conversion's timing and result are unchanged, and no second conversion follows.
- R8: `res_valid` rises AZ_CYCLES + 2^CNT_W + k + 1 clock edges after the edge that samples `start`. In the over-range case, k is taken as 2^CNT_W − 1.
- R9: `busy` is high from the edge that samples `start` through the `res_valid` cycle, and is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a conversion when sampled high while idle |
| zero_cross | input | 1 | Comparator: high when the integrator is at or past zero |
| sw_sel | output | 3 | One-hot switch select: [0] input, [1] negative reference, [2] zero path |
| busy | output | 1 | Conversion in progress |
| result | output | CNT_W | Run-down count of the last conversion |
| over_range | output | 1 | Last conversion saturated |
| res_valid | output | 1 | One-clock pulse when `result` is loaded |

## Verification
A corrupted state or counter shows up first at `sw_sel`. A phase that starts late, ends early or runs long changes the number of clocks the input or the reference is selected, and that can be seen within one clock of the fault. The same fault shifts the rise of `res_valid` away from the expected latency. Because the integrator is modelled from `sw_sel` itself, a run-up length that is wrong by even one clock also moves the comparator trip and changes `result` at the end of that conversion.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_AZERO = 3'd1,
    ST_INTEG = 3'd2,
    ST_DEINT = 3'd3,
    ST_DONE  = 3'd4
  } dsc_state_e;

  localparam int SW_W    = 3;
  localparam int SW_IN   = 0;
  localparam int SW_REF  = 1;
  localparam int SW_ZERO = 2;
endpackage

// File: rtl/dsc_phase_cnt.sv
module dsc_phase_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_max = &cnt;
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int W         = 8,
  parameter int AZ_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            zc,
  input  logic [W-1:0]    cnt,
  input  logic            at_max,
  output dsc_state_e      state_o,
  output logic            cnt_clr,
  output logic            cnt_inc,
  output logic            load,
  output logic            over_load,
  output logic [SW_W-1:0] sw_sel
);
  localparam logic [W-1:0] AZ_LAST = W'(AZ_CYCLES - 1);

  dsc_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    load      = 1'b0;
    over_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (start) state_d = ST_AZERO;
      end
      ST_AZERO: begin
        cnt_inc = 1'b1;
        if (cnt == AZ_LAST) begin
          cnt_clr = 1'b1;
          state_d = ST_INTEG;
        end
      end
      ST_INTEG: begin
        cnt_inc = 1'b1;
        if (at_max) begin
          cnt_clr = 1'b1;
          state_d = ST_DEINT;
        end
      end
      ST_DEINT: begin
        cnt_inc = 1'b1;
        if (zc) begin
          load    = 1'b1;
          state_d = ST_DONE;
        end else if (at_max) begin
          load      = 1'b1;
          over_load = 1'b1;
          state_d   = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    sw_sel = '0;
    case (state_q)
      ST_INTEG: sw_sel[SW_IN]   = 1'b1;
      ST_DEINT: sw_sel[SW_REF]  = 1'b1;
      default:  sw_sel[SW_ZERO] = 1'b1;
    endcase
  end

  assign state_o = state_q;

  AST_SW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sw_sel) == 1); // R2
  AST_RUNUP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INTEG && !at_max) |=> state_q == ST_INTEG); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_DONE) |=> state_q != ST_IDLE); // R7
endmodule

// File: rtl/dsc_result.sv
module dsc_result #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         over_in,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] result,
  output logic         over_range,
  output logic         res_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result     <= '0;
      over_range <= 1'b0;
      res_valid  <= 1'b0;
    end else begin
      res_valid <= load;
      if (load) begin
        result     <= over_in ? '1 : cnt;
        over_range <= over_in;
      end
    end
  end

  AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(result) && $stable(over_range))); // R5
  AST_OVER_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    over_range |-> &result); // R6
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int AZ_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             zero_cross,
  output logic [2:0]       sw_sel,
  output logic             busy,
  output logic [CNT_W-1:0] result,
  output logic             over_range,
  output logic             res_valid
);
  logic [CNT_W-1:0] cnt;
  logic             at_max, cnt_clr, cnt_inc, load, over_load;
  dsc_state_e       state;

  dsc_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .cnt(cnt), .at_max(at_max)
  );

  dsc_ctrl #(.W(CNT_W), .AZ_CYCLES(AZ_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .zc(zero_cross),
    .cnt(cnt), .at_max(at_max), .state_o(state),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .load(load),
    .over_load(over_load), .sw_sel(sw_sel)
  );

  dsc_result #(.W(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .load(load), .over_in(over_load),
    .cnt(cnt), .result(result), .over_range(over_range),
    .res_valid(res_valid)
  );

  assign busy = (state != ST_IDLE);

  logic in_deint;
  assign in_deint = (state == ST_DEINT);

  AST_DEINT_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_deint) |-> cnt == '0); // R4
  AST_VALID_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (busy && sw_sel == 3'b100)); // R9
endmodule

// File: tb/sim_dual_slope_seq.sv
module sim_dual_slope_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int AZ  = 4;
  localparam int FS  = 1 << N;
  localparam int NV  = 9;
  localparam int VIN_T  [NV] = '{0, 1, 100, 50, 7, 255, 256, 99, 1};
  localparam int VREF_T [NV] = '{100, 256, 256, 200, 3, 256, 256, 128, 1000};

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] sw_sel;
  logic busy, over_range, res_valid;
  logic [N-1:0] result;
  longint acc, vin, vref;
  logic zc;
  int checks = 0, errors = 0;
  bit done_all = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_slope_seq #(.CNT_W(N), .AZ_CYCLES(AZ)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .zero_cross(zc),
    .sw_sel(sw_sel), .busy(busy), .result(result),
    .over_range(over_range), .res_valid(res_valid)
  );

  // integrator and comparator model
  always @(posedge clk) begin
    if (!rst_n) acc <= 0;
    else case (sw_sel)
      3'b001:  acc <= acc + vin;
      3'b010:  acc <= acc - vref;
      default: acc <= 0;
    endcase
  end
  assign zc = (acc <= 0);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int v, input int r, input bit poke,
                          output int lat, output int nz, output int ni, output int nr,
                          output bit busy0);
    vin = v; vref = r;
    @(negedge clk); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    lat = 0; nz = 0; ni = 0; nr = 0; busy0 = busy;
    while (!res_valid) begin
      case (sw_sel)
        3'b001:  ni++;
        3'b010:  nr++;
        3'b100:  nz++;
        default: ;
      endcase
      if (lat > 3000) begin
        chk(0, "R8 timeout", lat, 0);
        break;
      end
      @(negedge clk);
      start = (poke && (lat == 49 || lat == 300));
      lat++;
    end
    start = 0;
  endtask

  initial begin
    int lat, nz, ni, nr, k, kc, exp_res;
    bit exp_ovr, b0;
    repeat (3) @(negedge clk);
    chk(sw_sel == 3'b100, "R1 sw_sel", sw_sel, 4);
    chk(!busy && !res_valid && !over_range && result == 0, "R1 outputs",
        {busy, res_valid, over_range, result}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(sw_sel == 3'b100 && !busy && !res_valid, "R1 after release", sw_sel, 4);

    for (int i = 0; i < NV; i++) begin
      k = (VIN_T[i] * FS + VREF_T[i] - 1) / VREF_T[i];
      exp_ovr = (k > FS - 1);
      kc = exp_ovr ? FS - 1 : k;
      exp_res = kc;
      run_conv(VIN_T[i], VREF_T[i], (i == 3), lat, nz, ni, nr, b0);
      chk(result == exp_res[N-1:0], exp_ovr ? "R6 saturated result" : "R4 result", result, exp_res);
      chk(over_range == exp_ovr, "R6 over_range", over_range, exp_ovr);
      chk(lat == AZ + FS + kc + 1, "R8 latency", lat, AZ + FS + kc + 1);
      chk(nz == AZ, "R3 autozero clocks", nz, AZ);
      chk(ni == FS, "R3 run-up clocks", ni, FS);
      chk(nr == kc + 1, "R4 run-down clocks", nr, kc + 1);
      chk(b0 && busy, "R9 busy during conversion", {b0, busy}, 3);
      @(negedge clk);
      chk(!res_valid, "R5 single-clock valid", res_valid, 0);
      chk(!busy, "R9 busy low after done", busy, 0);
      chk(result == exp_res[N-1:0], "R5 result held", result, exp_res);
      if (i == 3) begin
        for (int j = 0; j < 6; j++) begin
          @(negedge clk);
          chk(!busy && !res_valid && sw_sel == 3'b100, "R7 no extra conversion",
              {busy, res_valid, sw_sel}, 4);
        end
      end
    end
    done_all = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_all) begin
      chk(0, "watchdog", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule